// File: doc/BRIEF.md
# I/O register bit-access unit

This unit owns a bank of 32 eight-bit peripheral registers and performs single-bit operations on them. A requester presents a command, a six-bit I/O address and a three-bit bit index. The command can set a bit, clear a bit, or test a bit for a skip decision. Only the lower half of the I/O space (addresses 0x00 to 0x1F) can be reached with bit commands. A request to any other address is dropped and an error pulse is raised.

Some register bits are status flags. A peripheral sets such a flag through a flag-set input, and software clears it by writing a one to that bit. A bit command changes only the addressed bit. It never writes ones back to neighbouring flags, so pending flags in the same register survive. A separate byte port gives a combinational byte read and a clocked byte write, with the same write-one-to-clear treatment of flag bits.

Three parameters set the layout of the bank: which bits are flags, which bits exist, and which registers are reserved. In the default layout the flag bits are register 0x02 bits 7:4, register 0x09 bits 3:0 and register 0x10 bits 7 and 0. Register 0x05 implements only bits 5:0. Registers 0x1B and 0x1C are reserved.

Top module: `iobit_unit`

## Requirements
- R1: After a synchronous reset every register reads 0x00 on the byte port, and `done`, `err` and `busy` are low.
- R2: A set command (`req_cmd`=0) on a plain bit is taken on the clock edge where `req_valid` is high and `busy` is low. `busy` is high in the next cycle. `done` pulses for one cycle in the cycle after that, and the byte port shows the bit set from that cycle on.
- R3: A clear command (`req_cmd`=1) on a plain bit clears that bit, with the same two-cycle timing as R2.
- R4: On a flag bit, a set command clears the flag and a clear command leaves it unchanged. Other bits of the same register, including pending flags, keep their values.
- R5: Command 2 tests whether the bit is clear and command 3 tests whether it is set. `done`, `bit_val` (the addressed bit) and `skip` (1 when the test condition holds) are valid in the cycle after the request. The tested register does not change.
- R6: A request with `req_addr` bit 5 set changes no register, even when its low five bits name a valid register. It raises `err` for one cycle in the cycle after the request, and `done` stays low.
- R7: A set or clear command to a reserved register is dropped with an `err` pulse. A test command on a reserved register completes with `bit_val`=0. A reserved register always reads 0x00, byte writes included.
- R8: Unimplemented bits (register 0x05 bits 7:6 by default) read 0 after byte writes and after bit commands.
- R9: A byte write stores the data into plain implemented bits. It clears flag bits where the data bit is 1 and keeps them where the data bit is 0. The new value can be read in the cycle after the write.
- R10: A flag-set input sets its flag bit at the next edge and wins over a clearing byte write or bit command in the same cycle. Flag-set inputs on non-flag bits have no effect.
- R11: A request presented while `busy` is high is ignored and produces neither `done` nor `err`.
- R12: A byte write to the register that a bit command updates on the same edge is dropped. A byte write to any other register on that edge takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bit command request |
| req_cmd | input | 2 | 0 set, 1 clear, 2 test for clear, 3 test for set |
| req_addr | input | 6 | I/O address; bit commands are valid only when bit 5 is 0 |
| req_bit | input | 3 | Bit index in the addressed register |
| busy | output | 1 | A set or clear command is in its second cycle |
| done | output | 1 | One-cycle completion pulse |
| bit_val | output | 1 | Tested bit value (valid with done of a test) |
| skip | output | 1 | Skip decision of a test (valid with done) |
| err | output | 1 | One-cycle pulse for a dropped request |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write data |
| rd_addr | input | 5 | Byte read register index |
| rd_data | output | 8 | Byte read data (combinational) |
| flag_set | input | 256 | Peripheral flag-set lines, 8 per register, register n at bits 8n+7:8n |

## Verification
Set and clear commands are applied to plain bits, to flag bits that sit next to other pending flags, to an unimplemented bit and to a reserved register. Comparing the register values afterwards separates a masked single-bit write from a read-modify-write that would clear the neighbouring flags. Both test polarities are run on bits that are 1 and bits that are 0, so an inverted skip cannot pass. An out-of-range address whose low bits alias a live register would show a wrongly decoded address as a changed byte. Collisions between a flag-set input and a byte write or bit command, and between a byte write and a bit-command write-back, check the stated priorities edge by edge.

// File: rtl/iob_pkg.sv
package iob_pkg;

    localparam int IOB_NREG = 32;
    localparam int IOB_DW   = 8;
    localparam int IOB_AW   = $clog2(IOB_NREG);
    localparam int IOB_BW   = $clog2(IOB_DW);
    localparam int IOB_MAPW = IOB_NREG * IOB_DW;

    typedef enum logic [1:0] {
        CMD_SET  = 2'd0,
        CMD_CLR  = 2'd1,
        CMD_SKPC = 2'd2,
        CMD_SKPS = 2'd3
    } bitcmd_e;

    typedef struct packed {
        bitcmd_e             cmd;
        logic [IOB_AW-1:0]   reg_idx;
        logic [IOB_BW-1:0]   bit_idx;
    } bitop_t;

    // default layout of write-one-to-clear flag bits
    function automatic logic [IOB_MAPW-1:0] dflt_w1c();
        logic [IOB_MAPW-1:0] m;
        m = '0;
        m[2*IOB_DW  +: IOB_DW] = 8'hF0;
        m[9*IOB_DW  +: IOB_DW] = 8'h0F;
        m[16*IOB_DW +: IOB_DW] = 8'h81;
        return m;
    endfunction

    // default reserved register set
    function automatic logic [IOB_NREG-1:0] dflt_rsvd();
        logic [IOB_NREG-1:0] r;
        r = '0;
        r[27] = 1'b1;
        r[28] = 1'b1;
        return r;
    endfunction

    // default implemented bits; reserved registers have none
    function automatic logic [IOB_MAPW-1:0] dflt_impl();
        logic [IOB_MAPW-1:0] m;
        m = '1;
        m[5*IOB_DW  +: IOB_DW] = 8'h3F;
        m[27*IOB_DW +: IOB_DW] = 8'h00;
        m[28*IOB_DW +: IOB_DW] = 8'h00;
        return m;
    endfunction

    // single-bit update: only the addressed bit may change
    function automatic logic [IOB_DW-1:0] apply_bit(
        input logic [IOB_DW-1:0] cur,
        input logic [IOB_DW-1:0] w1c,
        input logic [IOB_DW-1:0] impl,
        input logic [IOB_BW-1:0] pos,
        input logic              is_set
    );
        logic [IOB_DW-1:0] m;
        m = (IOB_DW'(1) << pos) & impl;
        if (is_set)
            return ((w1c & m) != '0) ? (cur & ~m) : (cur | m);
        else
            return ((w1c & m) != '0) ? cur : (cur & ~m);
    endfunction

    // byte update: plain bits take data, flag bits clear on one
    function automatic logic [IOB_DW-1:0] apply_byte(
        input logic [IOB_DW-1:0] cur,
        input logic [IOB_DW-1:0] w1c,
        input logic [IOB_DW-1:0] impl,
        input logic [IOB_DW-1:0] data
    );
        return (cur & w1c & ~data) | (data & impl & ~w1c);
    endfunction

endpackage

// File: rtl/iob_req_decode.sv
module iob_req_decode
    import iob_pkg::*;
(
    input  logic                 req_valid,
    input  logic [1:0]           req_cmd,
    input  logic [IOB_AW:0]      req_addr,
    input  logic [IOB_BW-1:0]    req_bit,
    input  logic                 busy,
    input  logic [IOB_NREG-1:0]  rsvd_regs,
    output logic                 acc_test,
    output logic                 acc_write,
    output logic                 reject,
    output bitop_t               op
);
    logic live, in_range, is_wr, is_rsvd;

    always_comb begin
        op.cmd     = bitcmd_e'(req_cmd);
        op.reg_idx = req_addr[IOB_AW-1:0];
        op.bit_idx = req_bit;
        live       = req_valid && !busy;
        in_range   = !req_addr[IOB_AW];
        is_wr      = (op.cmd == CMD_SET) || (op.cmd == CMD_CLR);
        is_rsvd    = rsvd_regs[op.reg_idx];
        reject     = live && (!in_range || (is_wr && is_rsvd));
        acc_write  = live && in_range && is_wr && !is_rsvd;
        acc_test   = live && in_range && !is_wr;
    end
endmodule

// File: rtl/iob_seq.sv
module iob_seq
    import iob_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_test,
    input  logic               acc_write,
    input  logic               reject,
    input  bitop_t             op,
    input  logic [IOB_DW-1:0]  test_byte,
    output logic               wb_en,
    output bitop_t             wb_op,
    output logic               busy,
    output logic               done,
    output logic               bit_val,
    output logic               skip,
    output logic               err
);
    logic   pend_q, done_q, err_q, bitv_q, skip_q;
    bitop_t op_q;
    logic   tbit;

    assign tbit = test_byte[op.bit_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            op_q   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            bitv_q <= 1'b0;
            skip_q <= 1'b0;
        end else begin
            pend_q <= acc_write;
            if (acc_write)
                op_q <= op;
            done_q <= acc_test | pend_q;
            err_q  <= reject;
            bitv_q <= acc_test & tbit;
            skip_q <= acc_test & (tbit ^ (op.cmd == CMD_SKPC));
        end
    end

    assign wb_en   = pend_q;
    assign wb_op   = op_q;
    assign busy    = pend_q;
    assign done    = done_q;
    assign err     = err_q;
    assign bit_val = bitv_q;
    assign skip    = skip_q;

    // R2
    write_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> (done_q && !pend_q));

    // R6
    err_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(err_q && done_q));

    // R11
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !(acc_write || acc_test || reject));
endmodule

// File: rtl/iob_regbank.sv
module iob_regbank
    import iob_pkg::*;
#(
    parameter logic [IOB_MAPW-1:0] W1C_MAP  = dflt_w1c(),
    parameter logic [IOB_MAPW-1:0] IMPL_MAP = dflt_impl()
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wb_en,
    input  bitop_t               wb_op,
    input  logic                 wr_en,
    input  logic [IOB_AW-1:0]    wr_addr,
    input  logic [IOB_DW-1:0]    wr_data,
    input  logic [IOB_MAPW-1:0]  flag_set,
    output logic [IOB_MAPW-1:0]  bank
);
    logic [IOB_DW-1:0] sel_m;
    assign sel_m = IOB_DW'(1) << wb_op.bit_idx;

    for (genvar i = 0; i < IOB_NREG; i++) begin : g_reg
        localparam logic [IOB_AW-1:0] IDX    = IOB_AW'(i);
        localparam logic [IOB_DW-1:0] W1C_R  = W1C_MAP[i*IOB_DW +: IOB_DW];
        localparam logic [IOB_DW-1:0] IMPL_R = IMPL_MAP[i*IOB_DW +: IOB_DW];

        logic [IOB_DW-1:0] reg_q, nxt, flg;
        logic              hit_bit, hit_byte;

        assign hit_bit  = wb_en && (wb_op.reg_idx == IDX);
        assign hit_byte = wr_en && (wr_addr == IDX) && !hit_bit;
        assign flg      = flag_set[i*IOB_DW +: IOB_DW] & W1C_R;

        always_comb begin
            nxt = reg_q;
            if (hit_bit)
                nxt = apply_bit(reg_q, W1C_R, IMPL_R, wb_op.bit_idx,
                                wb_op.cmd == CMD_SET);
            else if (hit_byte)
                nxt = apply_byte(reg_q, W1C_R, IMPL_R, wr_data);
            nxt = nxt | flg;
        end

        always_ff @(posedge clk) begin
            if (rst) reg_q <= '0;
            else     reg_q <= nxt;
        end

        assign bank[i*IOB_DW +: IOB_DW] = reg_q;

        // R4
        neighbour_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (hit_bit && flg == '0) |=>
            ((reg_q & ~$past(sel_m)) == ($past(reg_q) & ~$past(sel_m))));

        // R8
        unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_q & ~IMPL_R) == '0);

        // R10
        flag_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (flg != '0) |=> ((reg_q & $past(flg)) == $past(flg)));
    end
endmodule

// File: rtl/iobit_unit.sv
module iobit_unit
    import iob_pkg::*;
#(
    parameter logic [IOB_MAPW-1:0] W1C_MAP   = dflt_w1c(),
    parameter logic [IOB_MAPW-1:0] IMPL_MAP  = dflt_impl(),
    parameter logic [IOB_NREG-1:0] RSVD_REGS = dflt_rsvd()
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [1:0]           req_cmd,
    input  logic [IOB_AW:0]      req_addr,
    input  logic [IOB_BW-1:0]    req_bit,
    output logic                 busy,
    output logic                 done,
    output logic                 bit_val,
    output logic                 skip,
    output logic                 err,
    input  logic                 wr_en,
    input  logic [IOB_AW-1:0]    wr_addr,
    input  logic [IOB_DW-1:0]    wr_data,
    input  logic [IOB_AW-1:0]    rd_addr,
    output logic [IOB_DW-1:0]    rd_data,
    input  logic [IOB_MAPW-1:0]  flag_set
);
    logic               acc_test, acc_write, reject, wb_en;
    bitop_t             op, wb_op;
    logic [IOB_MAPW-1:0] bank;
    logic [IOB_DW-1:0]  test_byte;

    iob_req_decode u_dec (
        .req_valid (req_valid),
        .req_cmd   (req_cmd),
        .req_addr  (req_addr),
        .req_bit   (req_bit),
        .busy      (busy),
        .rsvd_regs (RSVD_REGS),
        .acc_test  (acc_test),
        .acc_write (acc_write),
        .reject    (reject),
        .op        (op)
    );

    assign test_byte = bank[op.reg_idx*IOB_DW +: IOB_DW];

    iob_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .acc_test  (acc_test),
        .acc_write (acc_write),
        .reject    (reject),
        .op        (op),
        .test_byte (test_byte),
        .wb_en     (wb_en),
        .wb_op     (wb_op),
        .busy      (busy),
        .done      (done),
        .bit_val   (bit_val),
        .skip      (skip),
        .err       (err)
    );

    iob_regbank #(
        .W1C_MAP  (W1C_MAP),
        .IMPL_MAP (IMPL_MAP)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wb_en    (wb_en),
        .wb_op    (wb_op),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .flag_set (flag_set),
        .bank     (bank)
    );

    assign rd_data = bank[rd_addr*IOB_DW +: IOB_DW];

    // R6
    out_of_range_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_addr[IOB_AW]) |=> (err && !done));
endmodule

// File: tb/iobit_unit_test.sv
module iobit_unit_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [1:0]   req_cmd = '0;
    logic [5:0]   req_addr = '0;
    logic [2:0]   req_bit = '0;
    logic         busy, done, bit_val, skip, err;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_addr = '0;
    logic [7:0]   wr_data = '0;
    logic [4:0]   rd_addr = '0;
    logic [7:0]   rd_data;
    logic [255:0] flag_set = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    typedef struct {
        int    cyc;
        bit    err;
        bit    bv;
        bit    sk;
        string tag;
    } exp_t;
    exp_t sb[$];

    iobit_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_bit(req_bit), .busy(busy), .done(done),
        .bit_val(bit_val), .skip(skip), .err(err), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .flag_set(flag_set)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop expected completions and compare
    always @(negedge clk) begin
        if (!rst && (done || err)) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected completion: done=%0b err=%0b, expected none", done, err);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (cyc != e.cyc || err != e.err || done != !e.err ||
                    bit_val != e.bv || skip != e.sk) begin
                    bad++;
                    $display("FAIL %s: cyc=%0d err=%0b done=%0b bv=%0b sk=%0b, expected cyc=%0d err=%0b done=%0b bv=%0b sk=%0b",
                             e.tag, cyc, err, done, bit_val, skip, e.cyc, e.err, !e.err, e.bv, e.sk);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic check_reg(input logic [4:0] a, input logic [7:0] expv, input string tag);
        rd_addr = a;
        #1;
        check(rd_data == expv, tag, rd_data, expv);
    endtask

    // driver: issue one request, push its expected completion
    task automatic issue(input logic [1:0] c, input logic [5:0] a, input logic [2:0] b,
                         input bit e_err, input bit e_bv, input bit e_sk, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_addr = a; req_bit = b;
        e.cyc = cyc + ((e_err || c >= 2) ? 1 : 2);
        e.err = e_err; e.bv = e_bv; e.sk = e_sk; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drive_cycle(input bit we, input logic [4:0] wa, input logic [7:0] wd,
                               input int freg, input logic [7:0] fval);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        flag_set = '0;
        if (freg >= 0) flag_set[freg*8 +: 8] = fval;
        @(negedge clk);
        wr_en = 1'b0; flag_set = '0;
    endtask

    task automatic wait_idle(input string tag);
        repeat (4) @(negedge clk);
        check(sb.size() == 0, tag, sb.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_reg(5'd2, 8'h00, "R1 reg2");
        check_reg(5'd9, 8'h00, "R1 reg9");
        check(!done && !err && !busy, "R1 outputs", {done, err, busy}, 0);

        // R2 set plain bit, busy in the following cycle
        issue(2'd0, 6'd3, 3'd4, 0, 0, 0, "R2 set timing");
        check(busy && !done, "R2 busy", {busy, done}, 2);
        wait_idle("R2 idle");
        check_reg(5'd3, 8'h10, "R2 reg3");
        issue(2'd0, 6'd3, 3'd0, 0, 0, 0, "R2 set b0");
        // R3 clear
        issue(2'd1, 6'd3, 3'd4, 0, 0, 0, "R3 clear");
        wait_idle("R3 idle");
        check_reg(5'd3, 8'h01, "R3 reg3");

        // R10 flags set by peripheral
        drive_cycle(0, 5'd0, 8'h00, 2, 8'hA0);
        check_reg(5'd2, 8'hA0, "R10 flag set");
        // R4 neighbour flags survive
        issue(2'd0, 6'd2, 3'd1, 0, 0, 0, "R4 set plain");
        wait_idle("R4 idle");
        check_reg(5'd2, 8'hA2, "R4 set beside flags");
        issue(2'd1, 6'd2, 3'd7, 0, 0, 0, "R4 clr flag");
        wait_idle("R4 idle");
        check_reg(5'd2, 8'hA2, "R4 clear on flag no effect");
        issue(2'd0, 6'd2, 3'd5, 0, 0, 0, "R4 set flag");
        wait_idle("R4 idle");
        check_reg(5'd2, 8'h82, "R4 set clears one flag only");

        // R5 tests, both polarities
        issue(2'd3, 6'd2, 3'd7, 0, 1, 1, "R5 skps on 1");
        issue(2'd2, 6'd2, 3'd7, 0, 1, 0, "R5 skpc on 1");
        issue(2'd2, 6'd2, 3'd5, 0, 0, 1, "R5 skpc on 0");
        issue(2'd3, 6'd2, 3'd5, 0, 0, 0, "R5 skps on 0");
        wait_idle("R5 idle");
        check_reg(5'd2, 8'h82, "R5 unchanged");

        // R10 flag set wins over clearing bit command
        issue(2'd0, 6'd2, 3'd7, 0, 0, 0, "R10 set vs flag");
        flag_set[2*8 +: 8] = 8'h80;
        @(negedge clk);
        flag_set = '0;
        wait_idle("R10 idle");
        check_reg(5'd2, 8'h82, "R10 flag beats bit clear");
        drive_cycle(0, 5'd0, 8'h00, 3, 8'h40);
        check_reg(5'd3, 8'h01, "R10 non-flag ignored");

        // R6 out of range, aliasing register 3
        issue(2'd0, 6'h23, 3'd1, 1, 0, 0, "R6 set out of range");
        issue(2'd3, 6'h3F, 3'd0, 1, 0, 0, "R6 test out of range");
        wait_idle("R6 idle");
        check_reg(5'd3, 8'h01, "R6 reg3 untouched");

        // R7 reserved register
        issue(2'd0, 6'h1B, 3'd2, 1, 0, 0, "R7 set reserved");
        issue(2'd3, 6'h1B, 3'd2, 0, 0, 0, "R7 test reserved");
        wait_idle("R7 idle");
        drive_cycle(1, 5'h1B, 8'hFF, -1, 8'h00);
        check_reg(5'h1B, 8'h00, "R7 reserved reads zero");

        // R8 unimplemented bits
        drive_cycle(1, 5'd5, 8'hFF, -1, 8'h00);
        check_reg(5'd5, 8'h3F, "R8 byte write");
        issue(2'd0, 6'd5, 3'd7, 0, 0, 0, "R8 set unimpl");
        issue(2'd1, 6'd5, 3'd0, 0, 0, 0, "R8 clr b0");
        wait_idle("R8 idle");
        check_reg(5'd5, 8'h3E, "R8 after bit cmds");

        // R9 byte writes
        drive_cycle(0, 5'd0, 8'h00, 9, 8'h0F);
        check_reg(5'd9, 8'h0F, "R9 flags pending");
        drive_cycle(1, 5'd9, 8'h35, -1, 8'h00);
        check_reg(5'd9, 8'h3A, "R9 w1c byte write");
        drive_cycle(1, 5'd3, 8'hC3, -1, 8'h00);
        check_reg(5'd3, 8'hC3, "R9 plain byte write");

        // R10 flag set wins over clearing byte write
        drive_cycle(1, 5'd9, 8'h02, 9, 8'h02);
        check_reg(5'd9, 8'h0A, "R10 flag beats byte clear");

        // R11 request while busy is ignored
        issue(2'd0, 6'd3, 3'd5, 0, 0, 0, "R11 first");
        req_valid = 1'b1; req_cmd = 2'd0; req_addr = 6'd3; req_bit = 3'd2;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle("R11 idle");
        check_reg(5'd3, 8'hE3, "R11 second dropped");

        // R12 byte write colliding with write-back
        issue(2'd0, 6'd4, 3'd0, 0, 0, 0, "R12 set");
        wr_en = 1'b1; wr_addr = 5'd4; wr_data = 8'hF0;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle("R12 idle");
        check_reg(5'd4, 8'h01, "R12 same reg byte dropped");
        issue(2'd0, 6'd4, 3'd1, 0, 0, 0, "R12 set other");
        wr_en = 1'b1; wr_addr = 5'd6; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle("R12 idle");
        check_reg(5'd4, 8'h03, "R12 bit cmd applied");
        check_reg(5'd6, 8'h55, "R12 other reg byte applied");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule